// File: doc/BRIEF.md
# Two-Wire Bus Line Conditioner and Frame Monitor

This block sits between the raw clock and data pins of a two-wire serial bus (I2C) and the rest of a bus controller. Each line first crosses into the local clock domain through a two-flop synchronizer. It then passes a glitch filter that accepts a new level only after that level has been seen without a break for a programmable number of clocks. The cleaned lines go on to a condition detector. It emits a one-cycle pulse for every START and every STOP and keeps a bus-busy flag. A frame tracker counts clock rises inside each nine-clock byte frame, which is eight data bits and an acknowledge bit. It flags a bus error when a START or STOP turns up inside a frame.

The filter setting `filt_sel` = N gives a rejection width W = 3 + N clocks, so W runs from 3 to 18. Change it only while the bus is idle. The clean lines serve as the receive path of the controller. The pulses, the busy flag and the error status tell its state machine what the bus is doing.

Top module: `i2c_bus_watch`

## Requirements
- R1: While reset is held and after it is released, with both raw lines high, `scl_clean` and `sda_clean` read 1, `bus_busy`, `start_pulse`, `stop_pulse` and `bus_err` read 0, and `err_code` reads 8'hF8.
- R2: A raw level change that stays in place for at least W = 3 + `filt_sel` consecutive clocks reaches the clean output. If the raw input changes before rising edge 1, the clean output changes on rising edge W + 2 and is unchanged after edge W + 1.
- R3: A raw level change lasting W - 1 clocks or fewer never shows on the clean output. Two changes of a clean output are never less than three clocks apart.
- R4: A START is the clean data line falling while the clean clock line stays high. It gives `start_pulse` high for exactly one clock, the cycle after the clean data line falls.
- R5: A STOP is the clean data line rising while the clean clock line stays high. It gives `stop_pulse` high for exactly one clock, the cycle after the clean data line rises.
- R6: `bus_busy` becomes 1 in the same cycle as `start_pulse`. It becomes 0 in the same cycle as `stop_pulse`. It stays 1 across a repeated START.
- R7: While busy, clean clock rises are counted 1 to 9 through each frame and then wrap to 1. A START or STOP resets the count to 0. A START or STOP found when the count is 2 to 9 raises `bus_err` in the same cycle as its pulse. At count 0 or 1 it is legal: count 0 means no rise since the last condition, and count 1 means the first clock after an acknowledge.
- R8: `err_code` reads 8'h00 in a cycle where `bus_err` is high and 8'hF8 in every other cycle. Its low three bits are always 0.
- R9: Data-line changes while the clean clock line is low produce no START, STOP or error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw | input | 1 | Unsynchronized bus clock line |
| sda_raw | input | 1 | Unsynchronized bus data line |
| filt_sel | input | 4 | Filter setting N, rejection width 3+N clocks |
| scl_clean | output | 1 | Filtered clock line |
| sda_clean | output | 1 | Filtered data line |
| start_pulse | output | 1 | One-cycle pulse per START or repeated START |
| stop_pulse | output | 1 | One-cycle pulse per STOP |
| bus_busy | output | 1 | Bus owned between START and STOP |
| bus_err | output | 1 | One-cycle pulse for a condition inside a frame |
| err_code | output | 8 | 8'h00 during a bus error, 8'hF8 otherwise |

## Verification
The hardest case to reach is a START placed in the high phase of the acknowledge clock. To legitimately reach that point, the bench must first generate a START and then drive exactly nine clean clock rises without an intervening condition. It does this with bit-level tasks that hold every line level much longer than the widest filter. The expected sequence is an error-flagged START followed by a legal STOP at count 0, and a scoreboard queue checks that order. The boundary between a pulse of W - 1 clocks and one of W clocks is reached by driving raw pulses on the falling clock edge. Both the narrowest and the widest filter settings are used.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;
   localparam int          BASE_WIDTH   = 3;
   localparam logic [7:0]  CODE_IDLE    = 8'hF8;
   localparam logic [7:0]  CODE_BUS_ERR = 8'h00;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
   } line_evt_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter
   import i2c_watch_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   input  logic [SEL_W-1:0] width_sel,
   output logic             clean
);
   localparam int MAX_W = BASE_WIDTH + (1 << SEL_W) - 1;
   localparam int CNT_W = $clog2(MAX_W + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_glitch_filter: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic [CNT_W-1:0]       run_cnt;
   logic [CNT_W-1:0]       limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
   end

   assign synced = sync_q[SYNC_STAGES-1];
   // terminal count is width minus one: flip on the width-th differing sample
   assign limit  = CNT_W'(BASE_WIDTH) + CNT_W'(width_sel) - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         clean   <= 1'b1;
      end else if (synced == clean) begin
         run_cnt <= '0;
      end else if (run_cnt == limit) begin
         run_cnt <= '0;
         clean   <= synced;
      end else begin
         run_cnt <= run_cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
   import i2c_watch_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      scl_f,
   input  logic      sda_f,
   output line_evt_t evt,
   output logic      start_pulse,
   output logic      stop_pulse,
   output logic      bus_busy
);
   logic scl_d;
   logic sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   // conditions need the clock line high both before and after the data edge
   always_comb begin
      evt.start = scl_d & scl_f & sda_d & ~sda_f;
      evt.stop  = scl_d & scl_f & ~sda_d & sda_f;
      evt.rise  = ~scl_d & scl_f;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pulse <= 1'b0;
         stop_pulse  <= 1'b0;
         bus_busy    <= 1'b0;
      end else begin
         start_pulse <= evt.start;
         stop_pulse  <= evt.stop;
         if (evt.start)     bus_busy <= 1'b1;
         else if (evt.stop) bus_busy <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_frame_pos.sv
module i2c_frame_pos
   import i2c_watch_pkg::*;
#(
   parameter int FRAME_BITS = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  line_evt_t evt,
   input  logic      busy,
   output logic      bus_err
);
   localparam int LAST  = FRAME_BITS + 1;
   localparam int POS_W = $clog2(LAST + 1);

   logic [POS_W-1:0] pos;
   logic             cond;

   assign cond = evt.start | evt.stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos     <= '0;
         bus_err <= 1'b0;
      end else begin
         // position 1 is the first clock of a frame, where STOP and repeated START live
         bus_err <= cond && (pos >= POS_W'(2));
         if (cond) begin
            pos <= '0;
         end else if (evt.rise && busy) begin
            if (pos == POS_W'(LAST)) pos <= POS_W'(1);
            else                     pos <= pos + POS_W'(1);
         end
      end
   end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
   import i2c_watch_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = 4,
   parameter int FRAME_BITS  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_raw,
   input  logic             sda_raw,
   input  logic [SEL_W-1:0] filt_sel,
   output logic             scl_clean,
   output logic             sda_clean,
   output logic             start_pulse,
   output logic             stop_pulse,
   output logic             bus_busy,
   output logic             bus_err,
   output logic [7:0]       err_code
);
   localparam int LINES = 2;

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("i2c_bus_watch: SEL_W must lie in 1..5");
   end
   if (FRAME_BITS < 1) begin : g_bad_frame
      $error("i2c_bus_watch: FRAME_BITS must be positive");
   end

   logic [LINES-1:0] raw_vec;
   logic [LINES-1:0] clean_vec;
   line_evt_t        evt;

   assign raw_vec = {sda_raw, scl_raw};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      i2c_glitch_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .SEL_W       (SEL_W)
      ) u_filt (
         .clk       (clk),
         .rst_n     (rst_n),
         .raw       (raw_vec[g]),
         .width_sel (filt_sel),
         .clean     (clean_vec[g])
      );
   end

   assign scl_clean = clean_vec[0];
   assign sda_clean = clean_vec[1];

   i2c_cond_detect u_det (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_f       (clean_vec[0]),
      .sda_f       (clean_vec[1]),
      .evt         (evt),
      .start_pulse (start_pulse),
      .stop_pulse  (stop_pulse),
      .bus_busy    (bus_busy)
   );

   i2c_frame_pos #(
      .FRAME_BITS (FRAME_BITS)
   ) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .busy    (bus_busy),
      .bus_err (bus_err)
   );

   assign err_code = bus_err ? CODE_BUS_ERR : CODE_IDLE;
endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_clean,
   input logic       sda_clean,
   input logic       start_pulse,
   input logic       stop_pulse,
   input logic       bus_busy,
   input logic       bus_err
);
   assert_min_width_scl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scl_clean) |=> $stable(scl_clean));
   assert_min_width_sda_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_clean) |=> $stable(sda_clean));
   assert_start_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> ($past(scl_clean) && !$past(sda_clean)));
   assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);
   assert_stop_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> ($past(scl_clean) && $past(sda_clean)));
   assert_stop_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |=> !stop_pulse);
   assert_busy_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> bus_busy);
   assert_busy_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> !bus_busy);
   assert_err_with_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (start_pulse || stop_pulse));
endmodule

bind i2c_bus_watch i2c_bus_watch_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_clean   (scl_clean),
   .sda_clean   (sda_clean),
   .start_pulse (start_pulse),
   .stop_pulse  (stop_pulse),
   .bus_busy    (bus_busy),
   .bus_err     (bus_err)
);

// File: tb/sim_i2c_bus_watch.sv
module sim_i2c_bus_watch;
   typedef enum int {EV_START, EV_STOP, EV_ERR_START, EV_ERR_STOP} ev_t;
   typedef struct {
      ev_t   kind;
      string req;
   } exp_t;

   localparam int HOLD = 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_raw = 1'b1;
   logic       sda_raw = 1'b1;
   logic [3:0] filt_sel = 4'd0;
   logic       scl_clean, sda_clean, start_pulse, stop_pulse, bus_busy, bus_err;
   logic [7:0] err_code;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #2 clk = ~clk;

   i2c_bus_watch u0 (
      .clk (clk), .rst_n (rst_n), .scl_raw (scl_raw), .sda_raw (sda_raw),
      .filt_sel (filt_sel), .scl_clean (scl_clean), .sda_clean (sda_clean),
      .start_pulse (start_pulse), .stop_pulse (stop_pulse), .bus_busy (bus_busy),
      .bus_err (bus_err), .err_code (err_code)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   endtask

   task automatic expect_ev(input ev_t k, input string req);
      exp_t e;
      e.kind = k;
      e.req  = req;
      sb.push_back(e);
   endtask

   task automatic drive(input logic c, input logic d);
      @(negedge clk);
      scl_raw = c;
      sda_raw = d;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      drive(1'b0, b);
      drive(1'b1, b);
      drive(1'b0, b);
   endtask

   task automatic do_start();   // from idle (1,1)
      drive(1'b1, 1'b0);
      drive(1'b0, 1'b0);
   endtask

   task automatic do_stop();    // from clock low
      drive(1'b0, 1'b0);
      drive(1'b1, 1'b0);
      drive(1'b1, 1'b1);
   endtask

   task automatic do_restart(); // from clock low
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b0);
      drive(1'b0, 1'b0);
   endtask

   // monitor: pops the scoreboard on every observed condition pulse
   always @(negedge clk) begin
      if (rst_n && (start_pulse || stop_pulse)) begin
         ev_t obs;
         if (start_pulse) obs = bus_err ? EV_ERR_START : EV_START;
         else             obs = bus_err ? EV_ERR_STOP  : EV_STOP;
         if (sb.size() == 0) begin
            chk(1'b0, "R9", "unexpected event", int'(obs), -1);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(obs == e.kind, e.req, "event kind", int'(obs), int'(e.kind));
         end
         chk(err_code == (bus_err ? 8'h00 : 8'hF8), "R8", "err_code",
             int'(err_code), bus_err ? 0 : 'hF8);
      end
   end

   // R2 exact latency on the clock line (no bus events while data is high)
   task automatic filt_timing(input int n);
      int w;
      w = 3 + n;
      filt_sel = 4'(n);
      @(negedge clk);
      scl_raw = 1'b0;
      repeat (w + 1) @(negedge clk);
      chk(scl_clean == 1'b1, "R2", "clean before edge W+2", int'(scl_clean), 1);
      @(negedge clk);
      chk(scl_clean == 1'b0, "R2", "clean at edge W+2", int'(scl_clean), 0);
      scl_raw = 1'b1;
      repeat (HOLD) @(negedge clk);
   endtask

   // R3 pulse of W-1 clocks is rejected
   task automatic filt_glitch(input int n, input bit on_sda);
      int  w;
      bit  ok;
      w  = 3 + n;
      ok = 1'b1;
      filt_sel = 4'(n);
      @(negedge clk);
      if (on_sda) sda_raw = 1'b0; else scl_raw = 1'b0;
      repeat (w - 1) @(negedge clk);
      sda_raw = 1'b1;
      scl_raw = 1'b1;
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         if (!scl_clean || !sda_clean) ok = 1'b0;
      end
      chk(ok, "R3", on_sda ? "sda glitch visible" : "scl glitch visible", int'(ok), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(scl_clean && sda_clean && !bus_busy, "R1", "lines/busy in reset",
          {scl_clean, sda_clean, bus_busy}, 3'b110);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!start_pulse && !stop_pulse && !bus_err, "R1", "pulses idle",
          {start_pulse, stop_pulse, bus_err}, 0);
      chk(err_code == 8'hF8, "R1", "err_code idle", int'(err_code), 'hF8);

      filt_timing(0);
      filt_timing(15);
      filt_glitch(0, 1'b0);
      filt_glitch(15, 1'b0);
      filt_glitch(0, 1'b1);   // a START would appear if the glitch passed
      filt_glitch(15, 1'b1);

      // R2: W-clock pulse on data while clock high is accepted: START then STOP
      filt_sel = 4'd0;
      expect_ev(EV_START, "R4");
      expect_ev(EV_STOP,  "R5");
      @(negedge clk);
      sda_raw = 1'b0;
      repeat (3) @(negedge clk);
      sda_raw = 1'b1;
      repeat (HOLD) @(negedge clk);
      chk(!bus_busy, "R6", "busy after short START/STOP", int'(bus_busy), 0);

      // R9: data toggles with clock low on an idle bus
      filt_sel = 4'd2;
      drive(1'b0, 1'b1);
      drive(1'b0, 1'b0);
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b1);
      chk(sb.size() == 0 && !bus_busy, "R9", "no event for low-clock toggles",
          int'(bus_busy), 0);

      // full byte plus acknowledge then STOP, legal (R7 position 1)
      expect_ev(EV_START, "R4");
      do_start();
      chk(bus_busy, "R6", "busy after START", int'(bus_busy), 1);
      for (int i = 0; i < 9; i++) send_bit(i[0]);
      expect_ev(EV_STOP, "R7");
      do_stop();
      chk(!bus_busy, "R6", "busy after STOP", int'(bus_busy), 0);

      // repeated START between two bytes
      expect_ev(EV_START, "R4");
      do_start();
      for (int i = 0; i < 9; i++) send_bit(1'b0);
      expect_ev(EV_START, "R7");
      do_restart();
      chk(bus_busy, "R6", "busy across repeated START", int'(bus_busy), 1);
      for (int i = 0; i < 9; i++) send_bit(1'b1);
      expect_ev(EV_STOP, "R5");
      do_stop();
      chk(!bus_busy, "R6", "busy after final STOP", int'(bus_busy), 0);

      // STOP in the middle of a data byte: error
      expect_ev(EV_START, "R4");
      do_start();
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      expect_ev(EV_ERR_STOP, "R7");
      do_stop();
      chk(!bus_busy, "R6", "busy after error STOP", int'(bus_busy), 0);

      // START in the acknowledge high phase: error, then legal STOP at count 0
      expect_ev(EV_START, "R4");
      do_start();
      for (int i = 0; i < 8; i++) send_bit(1'b0);
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b1);
      expect_ev(EV_ERR_START, "R7");
      drive(1'b1, 1'b0);
      chk(bus_busy, "R6", "busy after error START", int'(bus_busy), 1);
      expect_ev(EV_STOP, "R7");
      drive(1'b1, 1'b1);
      chk(!bus_busy, "R6", "busy after STOP at count 0", int'(bus_busy), 0);

      // widest filter, legal transaction
      filt_sel = 4'd15;
      expect_ev(EV_START, "R2");
      do_start();
      for (int i = 0; i < 9; i++) send_bit(i[1]);
      expect_ev(EV_STOP, "R2");
      do_stop();

      repeat (10) @(negedge clk);
      chk(sb.size() == 0, "R7", "all expected events seen", sb.size(), 0);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      finish_run();
   end
endmodule